// File: doc/BRIEF.md
# Grouped Fixed-Priority Channel Arbiter

This block picks which of up to 32 DMA channels may use a shared memory bus next. Each channel raises a request bit. Every channel belongs to one of four priority levels, taken from bits 3:2 of its index, so the lower and upper halves of 16 channels repeat the same level pattern. Level 0 is the most urgent. The arbiter grants the most urgent level that has a request. Inside that level, a rotating pointer shares the bus fairly among the channels that are requesting.

A grant is a one-hot vector with a valid flag. It stays fixed for a whole burst. The winning channel ends its burst by pulsing the shared burst-done input. Arbitration happens at only two points: at that pulse, or whenever the bus is idle. A higher-level request that arrives during a lower-level burst therefore waits for that burst to finish, and is then served before any lower-level requester.

Top module: `grp_prio_arb`

## Requirements
- R1: `grantVec` has at most one bit set, and `grantValid` is high exactly when one bit is set.
- R2: After reset, `grantValid` is low and `grantVec` is zero. Each level's round-robin search starts at the lowest channel index of that level.
- R3: A channel's level is bits 3:2 of its index: channels 0-3 and 16-19 are level 0, 4-7 and 20-23 are level 1, 8-11 and 24-27 are level 2, 12-15 and 28-31 are level 3. At each arbitration the lowest-numbered level that has a request wins.
- R4: Within the winning level, the grant goes to the first requesting channel of that level above the channel that level last won, counting upward in index order and wrapping to the lowest index.
- R5: While a grant is held and `burstDone` is low, `grantVec` does not change, whatever `reqVec` does.
- R6: On a clock edge where `burstDone` is high during a grant, the next grant appears one cycle later if any channel requests. If none requests, `grantValid` falls one cycle later.
- R7: `burstDone` has no effect while no grant is held.
- R8: An arbitration grants only a channel whose request bit was high at that edge. An idle arbiter with a pending request grants it one cycle later.
- R9: A higher-level request that waits behind a lower-level burst wins the arbitration at that burst's end, ahead of every lower-level requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqVec | input | NUM_CH | Per-channel request bits |
| burstDone | input | 1 | Pulsed by the granted channel at the end of its burst |
| grantVec | output | NUM_CH | One-hot grant |
| grantValid | output | 1 | A grant is held |

## Verification
The bench builds the arbiter with the default of 32 channels. Both 16-channel halves are therefore present, and every level has eight members split across the two halves, so round-robin wrap-around between the halves can be exercised. A behavioural model compares the design every cycle. The directed phases cover:
- rotation within a level,
- a level-0 request that arrives during a level-1 burst,
- burst-done pulses while the arbiter is idle,
- random traffic with bursts of random length.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int NUM_LVL = 4;

  typedef struct packed {
    logic arb;   // take a new winner at this edge
    logic drop;  // release the bus with no successor
  } arbStrobe_t;

  function automatic logic [1:0] levelOf(input int idx);
    levelOf = 2'((idx & 15) >> 2);
  endfunction
endpackage

// File: rtl/arb_ctrl.sv
module arb_ctrl
  import arb_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       anyReq,
  input  logic       burstDone,
  output arbStrobe_t strobe,
  output logic       busy
);
  always_comb begin
    strobe.arb  = (!busy || burstDone) && anyReq;
    strobe.drop = busy && burstDone && !anyReq;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busy <= 1'b0;
    else if (strobe.arb)  busy <= 1'b1;
    else if (strobe.drop) busy <= 1'b0;
  end

  AST_IDLE_DONE_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !anyReq) |=> !busy); // R7
  AST_RELEASE: assert property (@(posedge clk) disable iff (!rstN)
    (busy && burstDone && !anyReq) |=> !busy); // R6
endmodule

// File: rtl/arb_dpath.sv
module arb_dpath
  import arb_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqVec,
  input  arbStrobe_t        strobe,
  output logic              anyReq,
  output logic [NUM_CH-1:0] grantVec
);
  localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
  localparam logic [IDX_W-1:0] PTR_RESET = IDX_W'(NUM_CH - 1);

  function automatic logic [NUM_CH-1:0] lvlMask(input int lvl);
    for (int i = 0; i < NUM_CH; i++) lvlMask[i] = (int'(levelOf(i)) == lvl);
  endfunction

  logic [NUM_LVL-1:0] lvlReq;
  logic [1:0]         winLvl;
  logic [IDX_W-1:0]   winner;
  logic [IDX_W-1:0]   lastPtr [NUM_LVL];

  for (genvar g = 0; g < NUM_LVL; g++) begin : g_lvl
    assign lvlReq[g] = |(reqVec & lvlMask(g));
  end

  assign anyReq = |lvlReq;

  always_comb begin
    winLvl = 2'd0;
    for (int l = NUM_LVL - 1; l >= 0; l--)
      if (lvlReq[l]) winLvl = 2'(l);
  end

  always_comb begin
    logic found;
    logic [NUM_CH-1:0] cand;
    found  = 1'b0;
    winner = '0;
    cand   = reqVec & lvlMask(int'(winLvl));
    for (int i = 0; i < NUM_CH; i++)
      if (!found && cand[i] && IDX_W'(i) > lastPtr[winLvl]) begin
        winner = IDX_W'(i);
        found  = 1'b1;
      end
    for (int i = 0; i < NUM_CH; i++)
      if (!found && cand[i] && IDX_W'(i) <= lastPtr[winLvl]) begin
        winner = IDX_W'(i);
        found  = 1'b1;
      end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      grantVec <= '0;
      for (int l = 0; l < NUM_LVL; l++) lastPtr[l] <= PTR_RESET;
    end else if (strobe.arb) begin
      grantVec        <= NUM_CH'(1) << winner;
      lastPtr[winLvl] <= winner;
    end else if (strobe.drop) begin
      grantVec <= '0;
    end
  end

  // Observational level of the held grant.
  logic [1:0] grantLvl;
  always_comb begin
    grantLvl = 2'd0;
    for (int i = 0; i < NUM_CH; i++)
      if (grantVec[i]) grantLvl = levelOf(i);
  end

  function automatic logic [NUM_CH-1:0] aboveMask(input logic [1:0] lvl);
    for (int i = 0; i < NUM_CH; i++) aboveMask[i] = (levelOf(i) < lvl);
  endfunction

  AST_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grantVec)); // R1
  AST_GRANT_REQUESTED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arb |=> ((grantVec & $past(reqVec)) != '0)); // R8
  AST_TOP_LEVEL_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strobe.arb |=> (($past(reqVec) & aboveMask(grantLvl)) == '0)); // R3
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.arb && !strobe.drop) |=> $stable(grantVec)); // R5
endmodule

// File: rtl/grp_prio_arb.sv
module grp_prio_arb
  import arb_pkg::*;
#(
  parameter int NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] reqVec,
  input  logic              burstDone,
  output logic [NUM_CH-1:0] grantVec,
  output logic              grantValid
);
  arbStrobe_t strobe;
  logic       anyReq;

  arb_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .anyReq(anyReq), .burstDone(burstDone),
    .strobe(strobe), .busy(grantValid)
  );

  arb_dpath #(.NUM_CH(NUM_CH)) u_dpath (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .strobe(strobe),
    .anyReq(anyReq), .grantVec(grantVec)
  );

  AST_VALID_MATCHES: assert property (@(posedge clk) disable iff (!rstN)
    grantValid == (grantVec != '0)); // R1
endmodule

// File: tb/grp_prio_arb_bench.sv
module grp_prio_arb_bench;
  localparam int N = 32;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic [N-1:0] reqVec = '0;
  logic         burstDone = 1'b0;
  logic [N-1:0] grantVec;
  logic         grantValid;

  int compared = 0;
  int mismatched = 0;

  // behavioural model state
  bit mBusy = 0;
  int mIdx = 0;
  int mPtr [4];

  always #4 clk = ~clk;

  grp_prio_arb #(.NUM_CH(N)) u_grp_prio_arb (
    .clk(clk), .rstN(rstN), .reqVec(reqVec), .burstDone(burstDone),
    .grantVec(grantVec), .grantValid(grantValid)
  );

  function automatic int lvl(int c);
    return (c % 16) / 4;
  endfunction

  task automatic compare(string tag);
    logic [N-1:0] expVec;
    expVec = mBusy ? (N'(1) << mIdx) : '0;
    compared++;
    if (grantValid !== mBusy || grantVec !== expVec) begin
      mismatched++;
      $display("FAIL %s t=%0t grantValid=%b/%b grantVec=%h expected %h",
               tag, $time, grantValid, mBusy, grantVec, expVec);
    end
  endtask

  // Called at a falling edge: check, drive, advance model to the next edge.
  task automatic step(string tag, logic [N-1:0] req, logic done);
    int best;
    compare(tag);
    reqVec = req;
    burstDone = done;
    if ((!mBusy || done) && req != '0) begin
      best = 4;
      for (int c = 0; c < N; c++) if (req[c] && lvl(c) < best) best = lvl(c);
      for (int k = 1; k <= N; k++) begin
        int c;
        c = (mPtr[best] + k) % N;
        if (req[c] && lvl(c) == best) begin
          mIdx = c;
          mPtr[best] = c;
          break;
        end
      end
      mBusy = 1;
    end else if (mBusy && done) begin
      mBusy = 0;
    end
    @(negedge clk);
  endtask

  localparam logic [N-1:0] LVL0 = 32'h000F_000F;

  initial begin
    for (int l = 0; l < 4; l++) mPtr[l] = N - 1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R2: reset state, nothing pending
    step("R2 reset", '0, 1'b0);
    // R8: idle request granted next cycle, R6 drop with no requester
    step("R8 single", 32'h20, 1'b0);
    step("R8 held", 32'h20, 1'b0);
    step("R6 done", '0, 1'b1);
    step("R6 idle", '0, 1'b0);
    // R7: done pulses while idle change nothing
    for (int i = 0; i < 3; i++) step("R7 idle done", '0, 1'b1);
    // R4: rotation across both halves of level 0, back-to-back
    for (int i = 0; i < 18; i++) step("R4 rotate", LVL0, 1'b1);
    step("R6 drain", '0, 1'b1);
    // R9/R5: level-1 burst held while level-0 and level-1 peers wait
    step("R5 start", 32'h0010_0000, 1'b0);
    for (int i = 0; i < 5; i++) step("R5 hold", 32'h0030_0002, 1'b0);
    step("R9 end", 32'h0030_0002, 1'b1);
    step("R9 next", 32'h0030_0000, 1'b1);
    step("R9 after", '0, 1'b1);
    // R3: all channels request, levels served in order
    for (int i = 0; i < 10; i++) step("R3 all", '1, 1'b1);
    step("R3 drain", '0, 1'b1);
    // R1: random traffic with random burst length
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] r;
      r = N'($urandom()) & N'($urandom());
      step("R1 random", r, ($urandom() % 3) == 0);
    end
    compare("R1 final");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #1000000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule